// File: doc/BRIEF.md
# Word Clock Regenerator with Quarter-Period Output

This block runs on a fast system clock and handles the word clock of an audio clock section. A meter measures the incoming word clock in system clock cycles. It decides whether that input is trustworthy and sorts it into single, double or quad speed without any configuration. A rate selector picks the period that the outputs should follow. That period comes from one of three places: the measured word clock, a period reported for another clock input, or a built-in master rate. When the chosen source disappears, the selector keeps the last good period.

A divider regenerates two outputs from that period. The standard output runs at the selected rate. While it is locked to the word clock input, it restarts on every input rising edge, so it stays in phase with the input and can feed other equipment. The second output always runs at single speed and lags by a quarter of its own period. At double speed its period is two standard periods, and at quad speed it is four. A status LED is lit steadily while the word clock input is valid and blinks with a 50% duty cycle otherwise.

Top module: `wck_regen`

## Requirements
- R1: The source select (0 master, 1 word clock input, 2 other input, 3 behaves as master) picks the rate. With source 2 and the other input valid, the standard output period equals `other_period`, and word clock input edges have no effect on it.
- R2: A measured or reported period P is classed as single speed (code 0) when P > SD_LIMIT, as double speed (code 1) when DQ_LIMIT < P <= SD_LIMIT, and as quad speed (code 2) otherwise. `speed_o` shows the class of the rate in use.
- R3: `wck_valid_o` rises only after GOOD_RUNS consecutive input periods that each lie in [MIN_PERIOD, MAX_PERIOD] and each differ from the previous period by no more than TOL cycles. An input whose period is out of range never becomes valid.
- R4: A valid input becomes invalid once more than twice its last measured period passes without a rising edge.
- R5: `led_o` is 1 on the cycle after the input is valid. While the input is invalid, `led_o` toggles every BLINK_HALF cycles.
- R6: In master mode the standard period is P48 (`master_base48`=1) or P441 (`master_base48`=0), shifted right by `master_speed` (0 single, 1 double, 2 quad, 3 single).
- R7: When the selected word clock or other input is not valid, the period and class in use keep their last values, and the standard output keeps running at that period.
- R8: While locked to a valid word clock input, the standard output rises exactly 3 system clocks after the input rises. The standard output is high for ceil(P/2) of every P cycles.
- R9: The quarter-period output has period Ps = m*P, where m is 1, 2 or 4 for the class in use. It is high for the phase positions x in [0, Ps) that satisfy Ps <= 4x < 3Ps. Its rising edge therefore comes ceil(Ps/4) mod P cycles after a standard output rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wck_in | input | 1 | Raw word clock input (asynchronous) |
| src_sel | input | 2 | Rate source: 0 master, 1 word clock, 2 other, 3 master |
| master_base48 | input | 1 | Master base rate: 1 selects 48 kHz family, 0 selects 44.1 kHz family |
| master_speed | input | 2 | Master speed: 0 single, 1 double, 2 quad, 3 single |
| other_period | input | PW | Period of the other selected input, in system clocks |
| other_valid | input | 1 | Other input is present |
| wck_std_o | output | 1 | Regenerated standard word clock |
| wck_quad_o | output | 1 | Single-speed word clock lagging by a quarter period |
| wck_valid_o | output | 1 | Word clock input judged valid |
| speed_o | output | 2 | Speed class of the rate in use |
| led_o | output | 1 | Status LED drive |

## Verification
The bench runs periods on each side of both class thresholds. A wrong comparison there would report the wrong `speed_o`, and the second output would divide by the wrong ratio. At quad speed the quarter-period lag equals a whole standard period, so the two outputs rise together. An off-by-one in the phase test would move the second output by a cycle or a full period. After the input stops, the bench checks that the output period does not change and that validity drops. A design without hold-over would fall back to a default rate, and one without a loss timeout would stay valid forever. Input that is too fast, input that is too slow, and toggling of the word clock pin while another source is selected must all leave the output rate untouched.

// File: rtl/wck_pkg.sv
package wck_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } spd_e;

  typedef enum logic [1:0] {
    SRC_MASTER = 2'd0,
    SRC_WCK    = 2'd1,
    SRC_OTHER  = 2'd2,
    SRC_MASTR2 = 2'd3
  } src_e;

  // Speed class from a period in system clocks: longer period, slower rate.
  function automatic spd_e classify(int p, int sd_lim, int dq_lim);
    if (p > sd_lim)      return SPD_SINGLE;
    else if (p > dq_lim) return SPD_DOUBLE;
    else                 return SPD_QUAD;
  endfunction

  // Number of standard periods inside one single-speed period.
  function automatic int spd_mult(spd_e s);
    case (s)
      SPD_DOUBLE: return 2;
      SPD_QUAD:   return 4;
      default:    return 1;
    endcase
  endfunction

  // Standard output level at phase c of a period p.
  function automatic logic std_level(int c, int p);
    return (2 * c) < p;
  endfunction

  // Quarter-lagged output level at phase pos of a period ps.
  function automatic logic quad_level(int pos, int ps);
    return ((4 * pos) >= ps) && ((4 * pos) < (3 * ps));
  endfunction

  // Internal rate period for master mode.
  function automatic int master_period(logic b48, logic [1:0] spd, int p48, int p441);
    int base;
    int sh;
    base = b48 ? p48 : p441;
    sh   = (spd == 2'd3) ? 0 : int'(spd);
    return base >> sh;
  endfunction

endpackage

// File: rtl/wck_meter.sv
module wck_meter
  import wck_pkg::*;
#(
  parameter int MIN_PERIOD = 909,
  parameter int MAX_PERIOD = 7143,
  parameter int TOL        = 4,
  parameter int GOOD_RUNS  = 3,
  parameter int PW         = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wck_in,
  output logic          rise_o,
  output logic          valid_o,
  output logic [PW-1:0] period_o
);

  localparam int CNT_MAX = 4 * MAX_PERIOD;
  localparam int RW      = $clog2(GOOD_RUNS + 1);

  logic [2:0]    sync_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] meas_q;
  logic [RW-1:0] run_q;

  int   cnt_i, meas_i, diff_i;
  logic in_rng, close, timeout, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], wck_in};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    cnt_i   = int'(cnt_q);
    meas_i  = int'(meas_q);
    diff_i  = (cnt_i > meas_i) ? (cnt_i - meas_i) : (meas_i - cnt_i);
    in_rng  = (cnt_i >= MIN_PERIOD) && (cnt_i <= MAX_PERIOD);
    close   = diff_i <= TOL;
    timeout = (cnt_i > 2 * meas_i) || (cnt_i >= CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      meas_q <= '0;
      run_q  <= '0;
    end else begin
      if (rise) begin
        cnt_q  <= PW'(1);
        meas_q <= cnt_q;
        if (in_rng && close)
          run_q <= (int'(run_q) >= GOOD_RUNS) ? run_q : run_q + RW'(1);
        else
          run_q <= '0;
      end else begin
        if (cnt_i < CNT_MAX) cnt_q <= cnt_q + PW'(1);
        if (timeout) run_q <= '0;
      end
    end
  end

  assign rise_o   = rise;
  assign valid_o  = int'(run_q) >= GOOD_RUNS;
  assign period_o = meas_q;

  AST_VALID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (int'(period_o) >= MIN_PERIOD && int'(period_o) <= MAX_PERIOD)); // R3
  AST_LOSS_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && timeout && !rise) |=> !valid_o); // R4

endmodule

// File: rtl/wck_rate_sel.sv
module wck_rate_sel
  import wck_pkg::*;
#(
  parameter int PW       = 15,
  parameter int P48      = 4167,
  parameter int P441     = 4535,
  parameter int SD_LIMIT = 3571,
  parameter int DQ_LIMIT = 1786
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_sel,
  input  logic          master_base48,
  input  logic [1:0]    master_speed,
  input  logic          wck_valid,
  input  logic [PW-1:0] wck_period,
  input  logic          other_valid,
  input  logic [PW-1:0] other_period,
  output logic [PW-1:0] per_o,
  output spd_e          spd_o,
  output logic          lock_o
);

  src_e          src;
  logic [PW-1:0] per_q;
  spd_e          spd_q;
  spd_e          mspd;

  assign src  = src_e'(src_sel);
  assign mspd = (master_speed == 2'd3) ? SPD_SINGLE : spd_e'(master_speed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= PW'(P48);
      spd_q <= SPD_SINGLE;
    end else begin
      case (src)
        SRC_WCK: begin
          if (wck_valid) begin
            per_q <= wck_period;
            spd_q <= classify(int'(wck_period), SD_LIMIT, DQ_LIMIT);
          end
        end
        SRC_OTHER: begin
          if (other_valid) begin
            per_q <= other_period;
            spd_q <= classify(int'(other_period), SD_LIMIT, DQ_LIMIT);
          end
        end
        default: begin
          per_q <= PW'(master_period(master_base48, master_speed, P48, P441));
          spd_q <= mspd;
        end
      endcase
    end
  end

  assign per_o  = per_q;
  assign spd_o  = spd_q;
  assign lock_o = (src == SRC_WCK) && wck_valid;

  AST_HOLD_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    ((src == SRC_WCK && !wck_valid) || (src == SRC_OTHER && !other_valid))
      |=> ($stable(per_q) && $stable(spd_q))); // R7
  AST_MASTER_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_MASTER || src == SRC_MASTR2)
      |=> int'(per_q) == master_period($past(master_base48), $past(master_speed), P48, P441)); // R6

endmodule

// File: rtl/wck_gen.sv
module wck_gen
  import wck_pkg::*;
#(
  parameter int PW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] per,
  input  spd_e          spd,
  input  logic          lock,
  input  logic          rise,
  output logic          std_o,
  output logic          quad_o
);

  logic [PW-1:0] c_q;
  logic [1:0]    k_q;
  int            per_i, mult, pos;
  logic          wrap;

  always_comb begin
    per_i = int'(per);
    mult  = spd_mult(spd);
    pos   = int'(k_q) * per_i + int'(c_q);
    wrap  = lock ? rise : (int'(c_q) >= per_i - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
      k_q <= '0;
    end else if (wrap) begin
      c_q <= '0;
      k_q <= (int'(k_q) + 1 >= mult) ? 2'd0 : k_q + 2'd1;
    end else if (int'(c_q) < per_i - 1) begin
      c_q <= c_q + PW'(1);
    end
  end

  assign std_o  = std_level(int'(c_q), per_i);
  assign quad_o = quad_level(pos, mult * per_i);

  AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && rise) |=> (c_q == '0)); // R8
  AST_LOCK_NO_EARLY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !rise && c_q != '0) |=> (c_q != '0)); // R8

endmodule

// File: rtl/wck_led.sv
module wck_led #(
  parameter int BLINK_HALF = 50000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid,
  output logic led_o
);

  localparam int BW = $clog2(BLINK_HALF + 1);

  logic [BW-1:0] cnt_q;
  logic          blink_q;
  logic          led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blink_q <= 1'b0;
      led_q   <= 1'b0;
    end else begin
      if (int'(cnt_q) >= BLINK_HALF - 1) begin
        cnt_q   <= '0;
        blink_q <= ~blink_q;
      end else begin
        cnt_q <= cnt_q + BW'(1);
      end
      led_q <= valid ? 1'b1 : blink_q;
    end
  end

  assign led_o = led_q;

  AST_LED_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> led_o); // R5

endmodule

// File: rtl/wck_regen.sv
module wck_regen
  import wck_pkg::*;
#(
  parameter int MIN_PERIOD = 909,
  parameter int MAX_PERIOD = 7143,
  parameter int TOL        = 4,
  parameter int GOOD_RUNS  = 3,
  parameter int SD_LIMIT   = 3571,
  parameter int DQ_LIMIT   = 1786,
  parameter int P48        = 4167,
  parameter int P441       = 4535,
  parameter int BLINK_HALF = 50000000,
  localparam int PW        = $clog2(4 * MAX_PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wck_in,
  input  logic [1:0]    src_sel,
  input  logic          master_base48,
  input  logic [1:0]    master_speed,
  input  logic [PW-1:0] other_period,
  input  logic          other_valid,
  output logic          wck_std_o,
  output logic          wck_quad_o,
  output logic          wck_valid_o,
  output logic [1:0]    speed_o,
  output logic          led_o
);

  logic          in_rise;
  logic          in_valid;
  logic [PW-1:0] in_period;
  logic [PW-1:0] use_per;
  spd_e          use_spd;
  logic          locked;

  wck_meter #(
    .MIN_PERIOD(MIN_PERIOD), .MAX_PERIOD(MAX_PERIOD), .TOL(TOL),
    .GOOD_RUNS(GOOD_RUNS), .PW(PW)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .wck_in(wck_in),
    .rise_o(in_rise), .valid_o(in_valid), .period_o(in_period)
  );

  wck_rate_sel #(
    .PW(PW), .P48(P48), .P441(P441), .SD_LIMIT(SD_LIMIT), .DQ_LIMIT(DQ_LIMIT)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
    .master_base48(master_base48), .master_speed(master_speed),
    .wck_valid(in_valid), .wck_period(in_period),
    .other_valid(other_valid), .other_period(other_period),
    .per_o(use_per), .spd_o(use_spd), .lock_o(locked)
  );

  wck_gen #(.PW(PW)) u_gen (
    .clk(clk), .rst_n(rst_n), .per(use_per), .spd(use_spd),
    .lock(locked), .rise(in_rise), .std_o(wck_std_o), .quad_o(wck_quad_o)
  );

  wck_led #(.BLINK_HALF(BLINK_HALF)) u_led (
    .clk(clk), .rst_n(rst_n), .valid(in_valid), .led_o(led_o)
  );

  assign wck_valid_o = in_valid;
  assign speed_o     = use_spd;

endmodule

// File: tb/sim_wck_regen.sv
`timescale 1ns/1ps
module sim_wck_regen;

  localparam int MINP = 45, MAXP = 360, TOLP = 2, RUNS = 3;
  localparam int SDL = 180, DQL = 90, PB48 = 208, PB441 = 226, BLINK = 500;
  localparam int PW = $clog2(4 * MAXP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wck_in = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic master_base48 = 1'b1;
  logic [1:0] master_speed = 2'd0;
  logic [PW-1:0] other_period = '0;
  logic other_valid = 1'b0;
  logic wck_std_o, wck_quad_o, wck_valid_o, led_o;
  logic [1:0] speed_o;

  always #2.5 clk = ~clk;

  wck_regen #(
    .MIN_PERIOD(MINP), .MAX_PERIOD(MAXP), .TOL(TOLP), .GOOD_RUNS(RUNS),
    .SD_LIMIT(SDL), .DQ_LIMIT(DQL), .P48(PB48), .P441(PB441), .BLINK_HALF(BLINK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wck_in(wck_in), .src_sel(src_sel),
    .master_base48(master_base48), .master_speed(master_speed),
    .other_period(other_period), .other_valid(other_valid),
    .wck_std_o(wck_std_o), .wck_quad_o(wck_quad_o), .wck_valid_o(wck_valid_o),
    .speed_o(speed_o), .led_o(led_o)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int std_r[$], quad_r[$], led_t[$], in_r[$];
  logic std_p = 1'b0, quad_p = 1'b0, led_p = 1'b0, seen_valid = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (wck_std_o && !std_p) std_r.push_back(cyc);
    if (wck_quad_o && !quad_p) quad_r.push_back(cyc);
    if (led_o != led_p) led_t.push_back(cyc);
    if (wck_valid_o) seen_valid = 1'b1;
    std_p = wck_std_o; quad_p = wck_quad_o; led_p = led_o;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int gap(int q[$]);
    if (q.size() < 2) return -1;
    return q[q.size()-1] - q[q.size()-2];
  endfunction

  function automatic int lag_meas(int qs[$], int ss[$]);
    int tq;
    if (qs.size() == 0) return -1;
    tq = qs[qs.size()-1];
    for (int i = ss.size() - 1; i >= 0; i--) if (ss[i] <= tq) return tq - ss[i];
    return -1;
  endfunction

  function automatic int exp_cls(int p);
    if (p > SDL) return 0;
    if (p > DQL) return 1;
    return 2;
  endfunction

  function automatic int exp_mult(int cls);
    return (cls == 0) ? 1 : (cls == 1) ? 2 : 4;
  endfunction

  function automatic int exp_lag(int p, int m);
    return ((p * m + 3) / 4) % p;
  endfunction

  function automatic int has(int q[$], int v);
    foreach (q[i]) if (q[i] == v) return 1;
    return 0;
  endfunction

  task automatic clear_q();
    std_r.delete(); quad_r.delete(); in_r.delete();
  endtask

  task automatic drive_wck(int p, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wck_in = 1'b1; in_r.push_back(cyc);
      repeat (p / 2) @(negedge clk);
      wck_in = 1'b0;
      repeat (p - p / 2 - 1) @(negedge clk);
    end
  endtask

  task automatic rate_checks(string req, int p, int cls);
    int m;
    m = exp_mult(cls);
    check({req, " std period"}, gap(std_r), p);
    check({req, " speed class"}, int'(speed_o), cls);
    check({"R9 ", req, " quad period"}, gap(quad_r), p * m);
    check({"R9 ", req, " quad lag"}, lag_meas(quad_r, std_r), exp_lag(p, m));
  endtask

  task automatic master_case(logic b48, logic [1:0] sp, int p, int cls);
    master_base48 = b48; master_speed = sp;
    repeat (300) @(negedge clk);
    clear_q();
    repeat (1000) @(negedge clk);
    rate_checks("R6 master", p, cls);
  endtask

  task automatic wck_case(int p);
    drive_wck(p, 8);
    clear_q();
    drive_wck(p, 6);
    check("R3 valid after steady input", int'(wck_valid_o), 1);
    check("R2 class", int'(speed_o), exp_cls(p));
    rate_checks("R2 locked", p, exp_cls(p));
    check("R8 std rises 3 clocks after input", has(std_r, in_r[in_r.size()-1] + 3), 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 reset valid", int'(wck_valid_o), 0);
    check("R5 reset led", int'(led_o), 0);
    check("R2 reset class", int'(speed_o), 0);

    // master rates
    master_case(1'b1, 2'd0, PB48, 0);
    master_case(1'b1, 2'd1, PB48 / 2, 1);
    master_case(1'b1, 2'd2, PB48 / 4, 2);
    master_case(1'b0, 2'd0, PB441, 0);
    master_case(1'b0, 2'd3, PB441, 0);

    // word clock input, each speed class
    src_sel = 2'd1;
    wck_case(200);
    check("R5 led solid while valid", int'(led_o), 1);
    wck_case(120);
    wck_case(60);

    // loss and hold-over
    led_t.delete();
    repeat (120) @(negedge clk);
    check("R4 valid drops after loss", int'(wck_valid_o), 0);
    clear_q();
    repeat (600) @(negedge clk);
    check("R7 hold-over period", gap(std_r), 60);
    check("R7 hold-over class", int'(speed_o), 2);

    // out-of-range inputs never validate; rate untouched
    seen_valid = 1'b0;
    drive_wck(30, 20);
    drive_wck(400, 5);
    check("R3 out-of-range never valid", int'(seen_valid), 0);
    clear_q();
    repeat (400) @(negedge clk);
    check("R7 rate kept after bad input", gap(std_r), 60);
    check("R5 blink half period", gap(led_t), BLINK);

    // other source, word clock pin toggling meanwhile
    src_sel = 2'd2; other_period = PW'(150); other_valid = 1'b1;
    repeat (300) @(negedge clk);
    clear_q();
    drive_wck(200, 10);
    rate_checks("R1 other source", 150, exp_cls(150));
    other_valid = 1'b0;
    clear_q();
    repeat (800) @(negedge clk);
    check("R7 other hold-over period", gap(std_r), 150);
    check("R7 other hold-over class", int'(speed_o), 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule